// File: doc/BRIEF.md
# Line-Sync Timing Pulse Generator

This block follows a stream of detected horizontal-sync events, delivered as an active-low sync level sampled on the pixel clock. Each falling edge of that level restarts a line position counter. Two line-rate pulses are decoded from the count. The first is a horizontal drive output that rises at position 0 and ends at a programmed time. The second is a DC-restore gate that starts at a programmed time and lasts a fixed 16 clocks. All times are measured from one shared origin, which lies a fixed clock after the registered sync edge.

The same counter also acts as a sync supervisor. After each restart, a window programmed in units of 4 clocks stays open. If no falling edge arrives before the window closes, the sync is declared missing. The block then raises a one-cycle flag, advances a saturating missing-sync count and restarts the line itself, so the pulses keep running. The next real edge clears the count.

A byte-wide register port sets the 10-bit times as low and high bytes, the window width, and a spare filter-adjust test byte.

Top module: `sync_pulse_gen`

## Requirements
- R1: After reset, the registers read back as follows: 0x0E=0x20, 0x0F=0x00, 0x10=0x00, 0x11=0xDD, 0x12=0x37, 0x13=0x00. All outputs are low and miss_cnt_o is 0.
- R2: The drive end time is split across two registers: bits 7-0 at 0x0E and bits 9-8 in bits 1-0 of 0x0F. The DC-restore start time uses 0x12 for bits 7-0 and 0x13 for bits 9-8. The test byte is at 0x10 and the window byte at 0x11. Bits 7-2 of 0x0F and 0x13 read back 0. Unmapped addresses read 0 and ignore writes.
- R3: If sync_ni is first seen low at rising edge P0, line position 0 is the clock cycle between rising edges P1 and P2. Position k lasts from edge P(k+1) to edge P(k+2).
- R4: Once running, hdrive_o is high exactly at positions 0 through E-1, where E is the drive end time. E=0 gives no pulse.
- R5: Once running, dcres_o is high exactly at positions S through S+15, where S is the DC-restore start time.
- R6: Before the first sync falling edge after reset, hdrive_o, dcres_o and sync_miss_o stay low.
- R7: With window value W, if no falling edge is detected by position 4W-1, sync_miss_o is high for that one cycle and the next cycle is position 0.
- R8: miss_cnt_o increases by one for each missing event and holds at 255. It reads 0 from position 0 after a detected falling edge.
- R9: Only a falling edge of sync_ni restarts the line. Holding sync_ni low, or its rising edge, leaves the position count running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_ni | input | 1 | Detected horizontal sync level, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for reg_addr_i, combinational |
| hdrive_o | output | 1 | Horizontal drive pulse |
| dcres_o | output | 1 | DC-restore gate pulse |
| sync_miss_o | output | 1 | One-cycle missing-sync flag |
| miss_cnt_o | output | 8 | Saturating count of consecutive missing syncs |

## Verification
The bench uses the default parameters: 10-bit times, an 8-bit window in 4-clock units, a 16-clock restore pulse and an 8-bit miss count. Short windows of 24 and 160 clocks allow every line position to be checked against arithmetic expectations over a grid of drive-end and restore-start values, including a drive end of zero. A 24-clock window lets 262 consecutive missing lines run in a few thousand cycles, so the count can be seen reaching and holding 255. A maximum window of 1020 clocks covers high-byte times above 255 and a sync held low across most of a line.

// File: rtl/sync_pulse_pkg.sv
package sync_pulse_pkg;
  localparam logic [7:0] ADDR_DRV_LO = 8'h0E;
  localparam logic [7:0] ADDR_DRV_HI = 8'h0F;
  localparam logic [7:0] ADDR_TEST   = 8'h10;
  localparam logic [7:0] ADDR_WIN    = 8'h11;
  localparam logic [7:0] ADDR_DC_LO  = 8'h12;
  localparam logic [7:0] ADDR_DC_HI  = 8'h13;

  localparam int RST_DRIVE_END = 32'h020;
  localparam int RST_DC_START  = 32'h037;
  localparam int RST_WIN       = 32'hDD;
  localparam int RST_TEST      = 32'h00;
endpackage

// File: rtl/lsp_regs.sv
module lsp_regs
  import sync_pulse_pkg::*;
#(
  parameter int TW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [7:0]    addr_i,
  input  logic [7:0]    wdata_i,
  output logic [7:0]    rdata_o,
  output logic [TW-1:0] drive_end_o,
  output logic [TW-1:0] dc_start_o,
  output logic [7:0]    win_o
);
  localparam int HW = TW - 8;

  logic [TW-1:0] drv_q, dc_q;
  logic [7:0]    test_q, win_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      drv_q  <= TW'(RST_DRIVE_END);
      dc_q   <= TW'(RST_DC_START);
      win_q  <= 8'(RST_WIN);
      test_q <= 8'(RST_TEST);
    end else if (we_i) begin
      case (addr_i)
        ADDR_DRV_LO: drv_q[7:0]    <= wdata_i;
        ADDR_DRV_HI: drv_q[TW-1:8] <= wdata_i[HW-1:0];
        ADDR_TEST:   test_q        <= wdata_i;
        ADDR_WIN:    win_q         <= wdata_i;
        ADDR_DC_LO:  dc_q[7:0]     <= wdata_i;
        ADDR_DC_HI:  dc_q[TW-1:8]  <= wdata_i[HW-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr_i)
      ADDR_DRV_LO: rdata_o = drv_q[7:0];
      ADDR_DRV_HI: rdata_o = 8'(drv_q[TW-1:8]);
      ADDR_TEST:   rdata_o = test_q;
      ADDR_WIN:    rdata_o = win_q;
      ADDR_DC_LO:  rdata_o = dc_q[7:0];
      ADDR_DC_HI:  rdata_o = 8'(dc_q[TW-1:8]);
      default:     rdata_o = 8'h00;
    endcase
  end

  assign drive_end_o = drv_q;
  assign dc_start_o  = dc_q;
  assign win_o       = win_q;
endmodule

// File: rtl/lsp_sync_edge.sv
module lsp_sync_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_ni,
  output logic fall_o
);
  logic s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b1;
      s2_q <= 1'b1;
    end else begin
      s1_q <= sync_ni;
      s2_q <= s1_q;
    end
  end

  assign fall_o = s2_q & ~s1_q;
endmodule

// File: rtl/lsp_line_timer.sv
module lsp_line_timer #(
  parameter int CW        = 11,
  parameter int WIN_W     = 8,
  parameter int WIN_SHIFT = 2,
  parameter int MISS_W    = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fall_i,
  input  logic [WIN_W-1:0]  win_i,
  output logic [CW-1:0]     pos_o,
  output logic              run_o,
  output logic              miss_o,
  output logic [MISS_W-1:0] miss_cnt_o
);
  logic [CW-1:0]     pos_q;
  logic              run_q;
  logic [MISS_W-1:0] miss_q;
  logic [CW:0]       pos_inc, win_len;
  logic              expire;

  assign win_len = (CW+1)'({win_i, {WIN_SHIFT{1'b0}}});
  assign pos_inc = {1'b0, pos_q} + (CW+1)'(1);
  // window closes when the next position would reach the programmed length
  assign expire  = run_q & ~fall_i & (pos_inc >= win_len);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q  <= '0;
      run_q  <= 1'b0;
      miss_q <= '0;
    end else if (fall_i) begin
      pos_q  <= '0;
      run_q  <= 1'b1;
      miss_q <= '0;
    end else if (expire) begin
      pos_q <= '0;
      if (miss_q != '1) miss_q <= miss_q + MISS_W'(1);
    end else if (run_q && pos_q != '1) begin
      pos_q <= pos_q + CW'(1);
    end
  end

  assign pos_o      = pos_q;
  assign run_o      = run_q;
  assign miss_o     = expire;
  assign miss_cnt_o = miss_q;

  a_r7_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire |=> (pos_q == '0))
    else $error("R7 no restart after window expiry");

  a_r8_sat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire && miss_q == '1) |=> (miss_q == '1))
    else $error("R8 miss count left saturation");

  a_r8_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_i |=> (miss_q == '0 && pos_q == '0 && run_q))
    else $error("R8 accepted edge did not clear");
endmodule

// File: rtl/lsp_pulse_gen.sv
module lsp_pulse_gen #(
  parameter int CW     = 11,
  parameter int TW     = 10,
  parameter int DC_LEN = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] pos_i,
  input  logic          run_i,
  input  logic [TW-1:0] drive_end_i,
  input  logic [TW-1:0] dc_start_i,
  output logic          hdrive_o,
  output logic          dcres_o
);
  logic [CW:0] pos_x, de_x, ds_x, ds_end;

  assign pos_x  = (CW+1)'(pos_i);
  assign de_x   = (CW+1)'(drive_end_i);
  assign ds_x   = (CW+1)'(dc_start_i);
  assign ds_end = ds_x + (CW+1)'(DC_LEN);

  assign hdrive_o = run_i & (pos_x < de_x);
  assign dcres_o  = run_i & (pos_x >= ds_x) & (pos_x < ds_end);

  a_r6_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |-> (!hdrive_o && !dcres_o))
    else $error("R6 pulse before first sync");

  a_r4_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && pos_i == '0 && drive_end_i != '0) |-> hdrive_o)
    else $error("R4 drive not high at position 0");
endmodule

// File: rtl/sync_pulse_gen.sv
module sync_pulse_gen #(
  parameter int TW        = 10,
  parameter int WIN_W     = 8,
  parameter int WIN_SHIFT = 2,
  parameter int DC_LEN    = 16,
  parameter int MISS_W    = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sync_ni,
  input  logic              reg_we_i,
  input  logic [7:0]        reg_addr_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  output logic              hdrive_o,
  output logic              dcres_o,
  output logic              sync_miss_o,
  output logic [MISS_W-1:0] miss_cnt_o
);
  localparam int TMAX = (TW > WIN_W + WIN_SHIFT) ? TW : WIN_W + WIN_SHIFT;
  localparam int CW   = TMAX + 1;

  logic [TW-1:0] drive_end, dc_start;
  logic [7:0]    win_reg;
  logic          fall, run;
  logic [CW-1:0] pos;

  lsp_regs #(.TW(TW)) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .rdata_o(reg_rdata_o), .drive_end_o(drive_end), .dc_start_o(dc_start),
    .win_o(win_reg)
  );

  lsp_sync_edge u_edge (.clk_i, .rst_ni, .sync_ni, .fall_o(fall));

  lsp_line_timer #(
    .CW(CW), .WIN_W(WIN_W), .WIN_SHIFT(WIN_SHIFT), .MISS_W(MISS_W)
  ) u_timer (
    .clk_i, .rst_ni, .fall_i(fall), .win_i(WIN_W'(win_reg)),
    .pos_o(pos), .run_o(run), .miss_o(sync_miss_o), .miss_cnt_o(miss_cnt_o)
  );

  lsp_pulse_gen #(.CW(CW), .TW(TW), .DC_LEN(DC_LEN)) u_pulse (
    .clk_i, .rst_ni, .pos_i(pos), .run_i(run),
    .drive_end_i(drive_end), .dc_start_i(dc_start),
    .hdrive_o, .dcres_o
  );
endmodule

// File: tb/sim_sync_pulse_gen.sv
`timescale 1ns/1ps
module sim_sync_pulse_gen;
  logic clk = 1'b0;
  logic rst_n, sync_n, we;
  logic [7:0] addr, wdata, rdata, mcnt;
  logic hdrv, dcr, miss;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sync_pulse_gen u0 (
    .clk_i(clk), .rst_ni(rst_n), .sync_ni(sync_n),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .hdrive_o(hdrv), .dcres_o(dcr), .sync_miss_o(miss), .miss_cnt_o(mcnt)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk); we = 1'b1; addr = 8'(a); wdata = 8'(d);
    @(negedge clk); we = 1'b0; addr = 8'h00;
  endtask

  task automatic rd_chk(input string req, input int a, input int exp);
    @(negedge clk); addr = 8'(a); #1;
    chk(req, int'(rdata), exp);
  endtask

  function automatic int eh(input int p, input int de);
    return (p < de) ? 1 : 0;
  endfunction
  function automatic int ed(input int p, input int ds);
    return (p >= ds && p < ds + 16) ? 1 : 0;
  endfunction

  // one line: fall at N0, rise at negedge rise_j, observe positions 0..npos-1
  task automatic do_line(input int de, input int ds, input int npos, input int rise_j);
    @(negedge clk); sync_n = 1'b0;
    for (int j = 1; j <= npos + 1; j++) begin
      @(negedge clk);
      if (j >= 2) begin
        chk("R4 hdrive", int'(hdrv), eh(j - 2, de));
        chk("R5 dcres", int'(dcr), ed(j - 2, ds));
        chk("R9 no miss", int'(miss), 0);
      end
      if (j == rise_j) sync_n = 1'b1;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int de_l[5] = '{0, 1, 5, 17, 60};
    int ds_l[4] = '{0, 3, 33, 50};
    sync_n = 1'b1; we = 1'b0; addr = 8'h00; wdata = 8'h00; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 hdrive", int'(hdrv), 0);
    chk("R1 dcres", int'(dcr), 0);
    chk("R1 miss", int'(miss), 0);
    chk("R1 count", int'(mcnt), 0);
    rd_chk("R1 0x0E", 8'h0E, 8'h20);
    rd_chk("R1 0x0F", 8'h0F, 8'h00);
    rd_chk("R1 0x10", 8'h10, 8'h00);
    rd_chk("R1 0x11", 8'h11, 8'hDD);
    rd_chk("R1 0x12", 8'h12, 8'h37);
    rd_chk("R1 0x13", 8'h13, 8'h00);

    wr(8'h0F, 8'hFF); rd_chk("R2 hi bits", 8'h0F, 8'h03);
    wr(8'h13, 8'hFE); rd_chk("R2 hi bits", 8'h13, 8'h02);
    wr(8'h0F, 0); wr(8'h13, 0);
    wr(8'h0E, 8'h2A); rd_chk("R2 drive lo", 8'h0E, 8'h2A);
    wr(8'h20, 8'h55); rd_chk("R2 unmapped", 8'h20, 8'h00);
    rd_chk("R2 unmapped write ignored", 8'h0E, 8'h2A);
    wr(8'h10, 8'hA5); rd_chk("R2 test", 8'h10, 8'hA5);
    wr(8'h11, 8'hFF); rd_chk("R2 window", 8'h11, 8'hFF);
    wr(8'h12, 8'h44); rd_chk("R2 dc lo", 8'h12, 8'h44);

    wr(8'h11, 40); wr(8'h0E, 5); wr(8'h12, 20);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      chk("R6 idle hdrive", int'(hdrv), 0);
      chk("R6 idle dcres", int'(dcr), 0);
      chk("R6 idle miss", int'(miss), 0);
    end

    // timing origin from idle
    @(negedge clk); sync_n = 1'b0;
    @(negedge clk); chk("R3 before origin", int'(hdrv), 0);
    @(negedge clk); chk("R3 at origin", int'(hdrv), 1);
    sync_n = 1'b1;

    foreach (de_l[a]) foreach (ds_l[b]) begin
      wr(8'h0E, de_l[a]); wr(8'h12, ds_l[b]);
      do_line(de_l[a], ds_l[b], 70, 4);
      chk("R8 count after lines", int'(mcnt), 0);
    end

    // long window, high-byte times, sync held low then released mid-line
    wr(8'h11, 8'hFF);
    wr(8'h0E, 8'h01); wr(8'h0F, 8'h01);
    wr(8'h12, 8'h04); wr(8'h13, 8'h01);
    do_line(257, 260, 300, 150);
    wr(8'h0F, 0); wr(8'h13, 0);

    // missing syncs: window 24 clocks
    wr(8'h11, 6); wr(8'h0E, 3); wr(8'h12, 5);
    @(negedge clk); sync_n = 1'b0;
    @(negedge clk); sync_n = 1'b1;
    for (int j = 2; j < 2 + 24 * 262; j++) begin
      int p, pp, m;
      @(negedge clk);
      p = j - 2; pp = p % 24; m = p / 24;
      if (m < 8 || m > 250) begin
        chk("R7 miss flag", int'(miss), (pp == 23) ? 1 : 0);
        chk("R7 free-run hdrive", int'(hdrv), eh(pp, 3));
        chk("R7 free-run dcres", int'(dcr), ed(pp, 5));
      end
      if (pp == 0) chk("R8 count", int'(mcnt), (m > 255) ? 255 : m);
    end

    // accepted edge clears the count
    @(negedge clk); sync_n = 1'b0;
    @(negedge clk); chk("R7 no miss on edge", int'(miss), 0);
    @(negedge clk);
    chk("R8 cleared", int'(mcnt), 0);
    chk("R3 origin after edge", int'(hdrv), 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule